// File: doc/BRIEF.md
# Cascadable Stereo Gain Control Serial Port

This block is the control-port front end of a two-channel programmable gain stage. A host drives three wires: an active-low select, a serial clock and a serial data line. While select is low, every rising serial clock edge shifts one bit into a 16-bit register. When select returns high, the register is copied into two 8-bit gain code outputs, and a single-cycle update strobe tells the downstream gain logic that new codes are present. The block does not interpret the codes.

All three serial inputs are oversampled by a system clock that runs at least four times faster than the serial clock. Each input passes through a two-flop synchronizer, and edges are found from the synchronized copies. A serial data output, with a separate output-enable for the pad, lets several ports be cascaded. The output changes on the falling serial clock edge and carries the bit leaving the top of the register. A chain of N ports therefore acts as one 16·N-bit shift register that commits on a shared select rise.

Top module: `gain_serial_port`

## Requirements
- R1: During and just after synchronous reset, both gain codes are 0x00, the update strobe is low, the serial output is 0 and its output-enable is low.
- R2: Bits are taken most significant first. After a 16-bit frame, the left code holds the first eight bits received and the right code holds the last eight.
- R3: The gain codes change only when select rises, and each select rise gives exactly one strobe pulse one system cycle long. The codes stay unchanged while a frame is being shifted.
- R4: Each rising serial clock edge with select low shifts the register left and takes the data input into bit 0. The following falling edge updates the serial output to register bit 15, so the output repeats the input stream 16 serial clocks late.
- R5: The output-enable is high while select is low and low while select is high. The serial output never changes while the output-enable is low.
- R6: Serial clock edges while select is high leave the shift register, the serial output and the gain codes unchanged.
- R7: With one port's serial output feeding the next port's data input, a 32-clock frame loads the second port with the first 16 bits sent and the first port with the last 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous to clk |
| sel_n_i | input | 1 | Active-low select |
| ser_din_i | input | 1 | Serial data in |
| ser_dout_o | output | 1 | Serial data out toward the next port in the chain |
| ser_dout_oe_o | output | 1 | High when the pad for ser_dout_o should drive |
| gain_left_o | output | 8 | Left channel gain code |
| gain_right_o | output | 8 | Right channel gain code |
| gain_update_o | output | 1 | One-cycle pulse when new codes are committed |

## Verification
A corrupted shift register is not visible on the gain outputs until the next select rise. On the serial output it shows within 16 serial clocks, because every bit reappears there exactly 16 clocks after it entered. For that reason the bench compares the serial output after every falling edge, and not only the committed codes. A broken edge detector or synchronizer shows up as an extra or missing strobe within four system cycles of a select rise. It also shows as a two-port chain where the second port's codes are off by one bit position. Clock activity while deselected is followed by a fresh frame, so any hidden change to the register appears on the serial output during that frame's first 16 clocks.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
  localparam int CODE_W   = 8;
  localparam int CHANNELS = 2;
  localparam int WORD_W   = CODE_W * CHANNELS;
  localparam int SYNC_N   = 2;

  // Bit order of the synchronized serial pin bundle
  localparam int PIN_SCLK = 2;
  localparam int PIN_SEL  = 1;
  localparam int PIN_DIN  = 0;
  localparam int PIN_W    = 3;
endpackage

// File: rtl/gsp_sync.sv
module gsp_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= RST_VAL;
    else     stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= RST_VAL;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gsp_edge.sv
module gsp_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk_s,
  input  logic sel_n_s,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sel_rise
);
  logic sclk_d;
  logic sel_n_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d  <= 1'b0;
      sel_n_d <= 1'b1;
    end else begin
      sclk_d  <= sclk_s;
      sel_n_d <= sel_n_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign sel_rise  = sel_n_s & ~sel_n_d;
endmodule

// File: rtl/gsp_shifter.sv
module gsp_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              din,
  input  logic              out_en,
  output logic [WORD_W-1:0] word_o,
  output logic              dout_o
);
  logic [WORD_W-1:0] shift_q;
  logic              dout_q;

  always_ff @(posedge clk) begin
    if (rst)           shift_q <= '0;
    else if (shift_en) shift_q <= {shift_q[WORD_W-2:0], din};
  end

  // Launch the bit leaving the top on the falling edge
  always_ff @(posedge clk) begin
    if (rst)         dout_q <= 1'b0;
    else if (out_en) dout_q <= shift_q[WORD_W-1];
  end

  assign word_o = shift_q;
  assign dout_o = dout_q;
endmodule

// File: rtl/gsp_gain_regs.sv
module gsp_gain_regs #(
  parameter int CODE_W   = 8,
  parameter int CHANNELS = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load,
  input  logic [CODE_W*CHANNELS-1:0]   word_i,
  output logic [CODE_W*CHANNELS-1:0]   codes_o,
  output logic                         strobe_o
);
  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    logic [CODE_W-1:0] code_q;
    always_ff @(posedge clk) begin
      if (rst)       code_q <= '0;
      else if (load) code_q <= word_i[c*CODE_W +: CODE_W];
    end
    assign codes_o[c*CODE_W +: CODE_W] = code_q;
  end

  always_ff @(posedge clk) begin
    if (rst) strobe_o <= 1'b0;
    else     strobe_o <= load;
  end
endmodule

// File: rtl/gain_serial_port.sv
module gain_serial_port
  import gsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              sel_n_i,
  input  logic              ser_din_i,
  output logic              ser_dout_o,
  output logic              ser_dout_oe_o,
  output logic [CODE_W-1:0] gain_left_o,
  output logic [CODE_W-1:0] gain_right_o,
  output logic              gain_update_o
);
  localparam logic [PIN_W-1:0] PIN_IDLE = PIN_W'(1) << PIN_SEL;

  logic [PIN_W-1:0]  pins_s;
  logic              sclk_rise, sclk_fall, sel_rise;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] codes;
  logic              oe_q;

  gsp_sync #(.WIDTH(PIN_W), .STAGES(SYNC_N), .RST_VAL(PIN_IDLE)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({ser_clk_i, sel_n_i, ser_din_i}),
    .sync_o  (pins_s)
  );

  gsp_edge u_edge (
    .clk       (clk),
    .rst       (rst),
    .sclk_s    (pins_s[PIN_SCLK]),
    .sel_n_s   (pins_s[PIN_SEL]),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .sel_rise  (sel_rise)
  );

  gsp_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (sclk_rise & ~pins_s[PIN_SEL]),
    .din      (pins_s[PIN_DIN]),
    .out_en   (sclk_fall & ~pins_s[PIN_SEL]),
    .word_o   (word),
    .dout_o   (ser_dout_o)
  );

  gsp_gain_regs #(.CODE_W(CODE_W), .CHANNELS(CHANNELS)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .load     (sel_rise),
    .word_i   (word),
    .codes_o  (codes),
    .strobe_o (gain_update_o)
  );

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= ~pins_s[PIN_SEL];
  end

  // First byte received ends up in the upper half: left channel
  assign gain_left_o   = codes[WORD_W-1 -: CODE_W];
  assign gain_right_o  = codes[CODE_W-1:0];
  assign ser_dout_oe_o = oe_q;
endmodule

// File: rtl/gsp_checker.sv
module gsp_checker #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ser_dout_o,
  input logic              ser_dout_oe_o,
  input logic [CODE_W-1:0] gain_left_o,
  input logic [CODE_W-1:0] gain_right_o,
  input logic              gain_update_o
);
  // R3: strobe lasts a single cycle
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (rst)
    gain_update_o |=> !gain_update_o);

  // R3: codes only move together with the strobe
  p_codes_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !gain_update_o |-> ($stable(gain_left_o) && $stable(gain_right_o)));

  // R5: commit happens after deselect, so the pad is released
  p_oe_off_at_commit_r5: assert property (@(posedge clk) disable iff (rst)
    gain_update_o |-> !ser_dout_oe_o);

  // R5: output is frozen while not driven
  p_dout_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    !ser_dout_oe_o |-> $stable(ser_dout_o));

  // R3: a commit needs a preceding selected period
  p_commit_after_select_r3: assert property (@(posedge clk) disable iff (rst)
    gain_update_o |-> $past(ser_dout_oe_o));
endmodule

bind gain_serial_port gsp_checker #(.CODE_W(gsp_pkg::CODE_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ser_dout_o    (ser_dout_o),
  .ser_dout_oe_o (ser_dout_oe_o),
  .gain_left_o   (gain_left_o),
  .gain_right_o  (gain_right_o),
  .gain_update_o (gain_update_o)
);

// File: tb/gain_serial_port_tb.sv
module gain_serial_port_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic sel_n = 1'b1;
  logic din = 1'b0;

  logic       dout1, oe1, upd1, dout2, oe2, upd2;
  logic [7:0] gl1, gr1, gl2, gr2;

  int checks = 0;
  int fails  = 0;
  int upd_cnt = 0;
  int upd2_cnt = 0;
  logic [31:0] chain = '0;
  bit done = 0;

  always #10 clk = ~clk;

  gain_serial_port dut_i (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .sel_n_i(sel_n), .ser_din_i(din),
    .ser_dout_o(dout1), .ser_dout_oe_o(oe1),
    .gain_left_o(gl1), .gain_right_o(gr1), .gain_update_o(upd1)
  );

  gain_serial_port dut2_i (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .sel_n_i(sel_n), .ser_din_i(dout1),
    .ser_dout_o(dout2), .ser_dout_oe_o(oe2),
    .gain_left_o(gl2), .gain_right_o(gr2), .gain_update_o(upd2)
  );

  always @(negedge clk) begin
    if (upd1) upd_cnt++;
    if (upd2) upd2_cnt++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Chain model: {port2, port1} behaves as one 32-bit register
  function automatic logic [31:0] shift_model(input logic [31:0] m, input logic b);
    return {m[30:0], b};
  endfunction

  task automatic send_frame(input logic [31:0] data, input int nbits);
    logic [7:0] held_l, held_r;
    held_l = gl1;
    held_r = gr1;
    upd_cnt = 0;
    upd2_cnt = 0;
    sel_n = 1'b0;
    tick(4);
    check(oe1 == 1'b1, "R5 oe while selected", 32'(oe1), 32'd1);
    for (int i = 0; i < nbits; i++) begin
      din = data[nbits-1-i];
      tick(4);
      sclk = 1'b1;
      chain = shift_model(chain, data[nbits-1-i]);
      tick(4);
      sclk = 1'b0;
      tick(4);
      check(dout1 == chain[15], "R4 dout port1", 32'(dout1), 32'(chain[15]));
      check(dout2 == chain[31], "R4 dout port2", 32'(dout2), 32'(chain[31]));
      if (i == nbits / 2)
        check(gl1 == held_l && gr1 == held_r && upd_cnt == 0,
              "R3 codes hold mid-frame", {gl1, gr1}, {held_l, held_r});
    end
    sel_n = 1'b1;
    tick(6);
    check(upd_cnt == 1, "R3 one strobe", 32'(upd_cnt), 32'd1);
    check(upd2_cnt == 1, "R3 one strobe port2", 32'(upd2_cnt), 32'd1);
    check(gl1 == chain[15:8] && gr1 == chain[7:0], "R2 codes port1",
          {gl1, gr1}, chain[15:0]);
    check(oe1 == 1'b0, "R5 oe released", 32'(oe1), 32'd0);
    if (nbits == 32)
      check(gl2 == chain[31:24] && gr2 == chain[23:16], "R7 chain port2",
            {gl2, gr2}, chain[31:16]);
  endtask

  task automatic idle_clocks(input int n);
    logic [7:0] l0, r0;
    logic d0;
    l0 = gl1; r0 = gr1; d0 = dout1;
    upd_cnt = 0;
    for (int i = 0; i < n; i++) begin
      din = 1'($urandom);
      tick(4);
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
    end
    tick(4);
    check(gl1 == l0 && gr1 == r0 && upd_cnt == 0, "R6 codes untouched",
          {gl1, gr1}, {l0, r0});
    check(dout1 == d0, "R6 dout untouched", 32'(dout1), 32'(d0));
  endtask

  initial begin
    void'($urandom(32'd2024));
    tick(5);
    check(gl1 == 8'h00 && gr1 == 8'h00, "R1 codes in reset", {gl1, gr1}, 32'h0);
    check(upd1 == 1'b0 && oe1 == 1'b0 && dout1 == 1'b0, "R1 outputs in reset",
          {upd1, oe1, dout1}, 32'h0);
    rst = 1'b0;
    tick(3);
    check(gl1 == 8'h00 && gr1 == 8'h00 && oe1 == 1'b0 && upd_cnt == 0,
          "R1 after reset", {gl1, gr1}, 32'h0);

    send_frame(32'h0000_A55A, 16);
    send_frame(32'h0000_FFFF, 16);
    send_frame(32'h0000_0000, 16);
    idle_clocks(7);
    send_frame(32'h0000_1234, 16);  // first 16 outputs expose any idle shift (R6)
    send_frame(32'hC3A5_0F81, 32);
    send_frame(32'h0000_0015, 5);
    for (int k = 0; k < 20; k++) begin
      if (k % 3 == 0) send_frame($urandom, 32);
      else            send_frame({16'h0, 16'($urandom)}, 16);
      if (k % 7 == 3) idle_clocks(3);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule